// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block is a general-purpose I/O controller for sixteen pins, reached through a simple 32-bit register port. Software sets an output value for each pin and decides whether the pin drives or listens. It reads the pin levels back after a two-stage synchroniser. It also picks, for each pin, the condition that raises an interrupt: a high level, a low level, a rising edge, a falling edge, or any change.

Interrupt events latch into a status register that software clears by writing ones. Each latched bit drives its own active-high request line towards a parent interrupt controller. Only the lower thirteen pins can raise requests. The upper three stay as plain I/O.

The register port is a single-cycle strobe. Writes take effect at the clock edge on which `reg_en` and `reg_wr` are both high. Reads return data combinationally while `reg_en` is high and `reg_wr` is low.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output data register (0x00) reads 0, the enable register (0x04) reads 0xFFFF, the status register (0x0C) and both style registers (0x10, 0x14) read 0, `pin_oe` is all zero and `irq_out` is all zero.
- R2: A write to 0x00 sets `pin_out` from wdata bits 15:0 on the next cycle. A write to 0x04 stores the enable bits. A stored 1 makes pin n an input (`pin_oe[n]`=0), and a stored 0 makes it drive (`pin_oe[n]`=1).
- R3: Reading 0x08 returns the pin levels after two flops of synchronisation. A level applied to `pin_in` reads back after two clock edges.
- R4: Each line has a 3-bit style field. Lines 0-7 use register 0x10 and lines 8-15 use register 0x14. Line k of a register (k = line mod 8) sits at bits [3k+2:3k]. Bits 31:24 of both registers read 0.
- R5: Style 0 (level high) and style 1 (level low) set the status bit on every clock the synchronised level matches. A clear written while the level persists leaves the bit set.
- R6: Style 2 sets status on a rising edge, style 3 on a falling edge, and style 4 on either edge of the synchronised input. A level that does not change sets nothing.
- R7: Style codes 5, 6 and 7 never set the status bit.
- R8: Writing to 0x0C clears exactly the status bits written as 1. An edge event in the same cycle as its clear leaves the bit set.
- R9: Lines 13, 14 and 15 never set status and never assert `irq_out`.
- R10: `irq_out[n]` is high exactly while status bit n is set. It stays high after the input returns to idle, until the bit is cleared.
- R11: Offsets 0x18 and 0x1C, and any other address outside the map, read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_en is high and reg_wr is low |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output value for each pin |
| pin_oe | output | 16 | 1 = pin driven by pin_out |
| irq_out | output | 16 | Active-high interrupt requests, one per line |

## Verification
A wrong style field decode shows up as a request on the wrong line, or no request at all. That appears on `irq_out` three clock edges after the pin moves: two synchroniser stages plus the status flop. A status register that loses or invents bits shows on `irq_out` in the very next cycle. A clear-versus-set priority fault appears only when a clear write meets a live event, so the bench times a clear onto the exact edge at which an event lands. Faults in the enable inversion or the output register reach `pin_oe` and `pin_out` one cycle after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int STY_W  = 3;

  localparam logic [ADDR_W-1:0] OFF_DOUT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_OEN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DIN   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STYLO = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_STYHI = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_CLKC  = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_DBSL  = 5'h1C;

  typedef enum logic [STY_W-1:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } irq_style_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = din;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign dout  = sync_q;
  assign dprev = prev_q;
endmodule

// File: rtl/gpio_line_irq.sv
module gpio_line_irq
  import gpio_irq_pkg::*;
#(
  parameter bit IRQ_CAPABLE = 1'b1
) (
  input  logic             cur,
  input  logic             prev,
  input  logic [STY_W-1:0] style,
  output logic             set
);
  generate
    if (IRQ_CAPABLE) begin : g_cap
      always_comb begin
        case (irq_style_e'(style))
          STY_LVL_HI: set = cur;
          STY_LVL_LO: set = ~cur;
          STY_RISE:   set = cur & ~prev;
          STY_FALL:   set = ~cur & prev;
          STY_ANY:    set = cur ^ prev;
          default:    set = 1'b0;
        endcase
      end
    end else begin : g_nocap
      logic unused_in;
      assign unused_in = cur ^ prev ^ (^style);
      assign set = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IRQ_LINES = 13,
  parameter int PER_REG   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int STY_BITS = PER_REG * STY_W;

  logic rst_sync_n;
  logic [NUM_LINES-1:0] in_cur, in_prev, line_set;

  logic [NUM_LINES-1:0] dout_q, dout_d, oen_q, oen_d, stat_q, stat_d;
  logic [NUM_LINES-1:0][STY_W-1:0] sty_q, sty_d;
  logic [STY_BITS-1:0] sty_lo_rd, sty_hi_rd;

  logic wr_dout, wr_oen, wr_stat, wr_slo, wr_shi;
  logic [NUM_LINES-1:0] clr_mask;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:STY_BITS];

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_in_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(pin_in), .dout(in_cur), .dprev(in_prev)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      gpio_line_irq #(.IRQ_CAPABLE(gi < IRQ_LINES)) u_det (
        .cur(in_cur[gi]), .prev(in_prev[gi]), .style(sty_q[gi]), .set(line_set[gi])
      );
      if (gi < PER_REG) begin : g_lo
        assign sty_lo_rd[gi*STY_W +: STY_W] = sty_q[gi];
      end else begin : g_hi
        assign sty_hi_rd[(gi-PER_REG)*STY_W +: STY_W] = sty_q[gi];
      end
    end
  endgenerate

  // write decode
  always_comb begin
    wr_dout = reg_en && reg_wr && (reg_addr == OFF_DOUT);
    wr_oen  = reg_en && reg_wr && (reg_addr == OFF_OEN);
    wr_stat = reg_en && reg_wr && (reg_addr == OFF_STAT);
    wr_slo  = reg_en && reg_wr && (reg_addr == OFF_STYLO);
    wr_shi  = reg_en && reg_wr && (reg_addr == OFF_STYHI);
    clr_mask = wr_stat ? reg_wdata[NUM_LINES-1:0] : '0;
  end

  // next state
  always_comb begin
    dout_d = wr_dout ? reg_wdata[NUM_LINES-1:0] : dout_q;
    oen_d  = wr_oen  ? reg_wdata[NUM_LINES-1:0] : oen_q;
    stat_d = (stat_q & ~clr_mask) | line_set;
    sty_d  = sty_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i < PER_REG) begin
        if (wr_slo) sty_d[i] = reg_wdata[(i % PER_REG)*STY_W +: STY_W];
      end else begin
        if (wr_shi) sty_d[i] = reg_wdata[(i % PER_REG)*STY_W +: STY_W];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q <= '0;
      oen_q  <= '1;
      stat_q <= '0;
      sty_q  <= '0;
    end else begin
      dout_q <= dout_d;
      oen_q  <= oen_d;
      stat_q <= stat_d;
      sty_q  <= sty_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_wr) begin
      case (reg_addr)
        OFF_DOUT:  reg_rdata[NUM_LINES-1:0] = dout_q;
        OFF_OEN:   reg_rdata[NUM_LINES-1:0] = oen_q;
        OFF_DIN:   reg_rdata[NUM_LINES-1:0] = in_cur;
        OFF_STAT:  reg_rdata[NUM_LINES-1:0] = stat_q;
        OFF_STYLO: reg_rdata[STY_BITS-1:0]  = sty_lo_rd;
        OFF_STYHI: reg_rdata[STY_BITS-1:0]  = sty_hi_rd;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = ~oen_q;
  assign irq_out = stat_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IRQ_LINES = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_en,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_oe,
  input logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] clr_bits;
  assign clr_bits = (reg_en && reg_wr && reg_addr == OFF_STAT) ? reg_wdata[NUM_LINES-1:0] : '0;

  // R9
  high_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[NUM_LINES-1:IRQ_LINES] == '0);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_out) & ~$past(clr_bits) & ~irq_out) == '0));

  // R2
  oe_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_wr && reg_addr == OFF_OEN) |=> (pin_oe == ~$past(reg_wdata[NUM_LINES-1:0])));

  // R2
  dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_wr && reg_addr == OFF_DOUT) |=> (pin_out == $past(reg_wdata[NUM_LINES-1:0])));

  // R11
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_wr && (reg_addr == OFF_CLKC || reg_addr == OFF_DBSL)) |-> (reg_rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {line[3:0], style[2:0], a, b, expected}
  localparam logic [9:0] VECS [NV] = '{
    {4'd0,  3'd0, 1'b1, 1'b1, 1'b1},
    {4'd1,  3'd0, 1'b0, 1'b0, 1'b0},
    {4'd2,  3'd1, 1'b1, 1'b0, 1'b1},
    {4'd3,  3'd1, 1'b1, 1'b1, 1'b0},
    {4'd4,  3'd2, 1'b0, 1'b1, 1'b1},
    {4'd5,  3'd2, 1'b1, 1'b0, 1'b0},
    {4'd6,  3'd3, 1'b1, 1'b0, 1'b1},
    {4'd7,  3'd3, 1'b0, 1'b1, 1'b0},
    {4'd9,  3'd4, 1'b0, 1'b1, 1'b1},
    {4'd10, 3'd4, 1'b1, 1'b0, 1'b1},
    {4'd11, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd8,  3'd5, 1'b0, 1'b1, 1'b0},
    {4'd12, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd13, 3'd2, 1'b0, 1'b1, 1'b0},
    {4'd15, 3'd0, 1'b1, 1'b1, 1'b0},
    {4'd14, 3'd7, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_en = 1'b0;
  endtask

  function automatic string vtag(input int line, input int style);
    if (line >= 13) return "R9";
    if (style <= 1) return "R5";
    if (style <= 4) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    rd(5'h00, d); chk("R1 dout", d, 32'h0);
    rd(5'h04, d); chk("R1 enable", d, 32'h0000FFFF);
    rd(5'h0C, d); chk("R1 status", d, 32'h0);
    rd(5'h10, d); chk("R1 style lo", d, 32'h0);
    rd(5'h14, d); chk("R1 style hi", d, 32'h0);
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 irq", {16'h0, irq_out}, 32'h0);

    // table walk: R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      int line, style;
      logic a, b, e;
      line = int'(VECS[v][9:6]); style = int'(VECS[v][5:3]);
      a = VECS[v][2]; b = VECS[v][1]; e = VECS[v][0];
      pin_in = '0;
      tick(4);
      wr(line < 8 ? 5'h10 : 5'h14, 32'(style) << (3 * (line % 8)));
      pin_in[line] = a;
      tick(4);
      wr(5'h0C, 32'hFFFF);
      pin_in[line] = b;
      tick(4);
      rd(5'h0C, d);
      chk({vtag(line, style), " status"}, {31'h0, d[line]}, {31'h0, e});
      chk({vtag(line, style), " R10 irq"}, {31'h0, irq_out[line]}, {31'h0, e});
    end
    pin_in = '0;
    wr(5'h0C, 32'hFFFF);

    // R2 output data and enable inversion
    wr(5'h00, 32'h0000A5C3);
    wr(5'h04, 32'h000000FF);
    chk("R2 pin_out", {16'h0, pin_out}, 32'h0000A5C3);
    chk("R2 pin_oe", {16'h0, pin_oe}, 32'h0000FF00);
    rd(5'h04, d); chk("R2 enable readback", d, 32'h000000FF);

    // R3 synchronised input
    pin_in = 16'h1234;
    tick(2);
    rd(5'h08, d); chk("R3 input", d, 32'h00001234);
    pin_in = '0;
    tick(3);

    // R4 style layout and upper bits
    wr(5'h10, 32'hFFFFFFFF);
    rd(5'h10, d); chk("R4 style lo upper zero", d, 32'h00FFFFFF);
    wr(5'h14, 32'h00000010);
    rd(5'h14, d); chk("R4 style hi field", d, 32'h00000010);

    // R11 reserved offsets
    wr(5'h18, 32'hFFFFFFFF);
    wr(5'h1C, 32'hFFFFFFFF);
    rd(5'h18, d); chk("R11 clk ctrl", d, 32'h0);
    rd(5'h1C, d); chk("R11 debounce", d, 32'h0);
    rd(5'h00, d); chk("R11 dout untouched", d, 32'h0000A5C3);

    // R8 partial clear: lines 4,5 rising
    wr(5'h10, 32'h0 | (32'd2 << 12) | (32'd2 << 15));
    wr(5'h14, 32'h0);
    wr(5'h0C, 32'hFFFF);
    tick(4);
    wr(5'h0C, 32'hFFFF);
    pin_in[4] = 1'b1; pin_in[5] = 1'b1;
    tick(4);
    wr(5'h0C, 32'h0010);
    rd(5'h0C, d); chk("R8 partial clear", d & 32'h0030, 32'h0020);
    pin_in[4] = 1'b0;
    tick(4);
    // R10 hold after idle
    chk("R10 irq holds", {31'h0, irq_out[5]}, 32'h1);
    wr(5'h0C, 32'h0020);
    chk("R10 irq drops", {31'h0, irq_out[5]}, 32'h0);

    // R8 edge event coincident with clear: line 4 already set
    pin_in[4] = 1'b1; tick(4); pin_in[4] = 1'b0; tick(4);
    rd(5'h0C, d); chk("R8 precondition", d & 32'h10, 32'h10);
    @(negedge clk); pin_in[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h0010;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
    rd(5'h0C, d); chk("R8 set beats clear", d & 32'h10, 32'h10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule